// File: doc/BRIEF.md
# Eight-Input Priority Interrupt Controller

This block gathers eight asynchronous interrupt request lines into a single interrupt output for a CPU with a byte-wide bus. It resolves requests by fixed priority, with input 0 highest. It tracks which levels the CPU is currently servicing, and it hands the CPU an 8-bit vector through a two-pulse acknowledge handshake. Each request can be captured on a rising edge or on a high level, and one programmable setting picks the mode for all eight lines.

The CPU programs the block through active-low select, read and write strobes, one address bit and a byte of write data. It reads back the pending requests, the in-service levels or the mask. The acknowledge input works whether or not the select line is low. The read data and the vector leave on a separate output byte together with an output-enable flag, so that the surrounding chip can build the shared bus.

The strobes and the acknowledge input are assumed to be synchronous to `clk`. Only the request lines are resynchronized.

Top module: `irq_hub`

## Requirements
- R1: Each request line passes through two synchronizer flops and a capture register. A line going high makes `irq` rise on the third rising clock edge after the change, and not earlier.
- R2: In edge mode a request is latched on a low-to-high transition and then stays pending while the line is held high. After it has been acknowledged, a line held high raises no new request. In level mode the pending bit follows the high level of the line, so a line held high asks again once it is no longer blocked.
- R3: In edge mode a pending request whose line drops low before the first acknowledge pulse is discarded, and `irq` falls.
- R4: `irq` is high exactly when some pending, unmasked request has no in-service level of equal or higher priority. Priority is fixed, and a lower index means higher priority.
- R5: A write with `addr`=1 loads the mask register, where bit i=1 masks input i. The mask resets to 0xFF. A write while `sel_n` is high changes nothing.
- R6: The first acknowledge pulse picks the highest-priority request that may interrupt. It sets that level's in-service bit and clears its pending bit.
- R7: The second acknowledge pulse drives `rdata` = {base[7:3], level[2:0]} with `rdata_oe` high while `ack_n` stays low. During the first pulse `rdata_oe` stays low. `sel_n` plays no part in the handshake.
- R8: If no request may interrupt at the first pulse, no in-service bit changes and the second pulse returns level 7.
- R9: A write of 0x20 with `addr`=0 clears only the lowest-index in-service bit.
- R10: A write with `addr`=0 and data bit 4 set does three things. It sets the trigger mode from data bit 3 (1 = level, 0 = edge). It clears the mask and all in-service bits. It makes the next `addr`=1 write load the vector base from data bits 7:3 instead of the mask.
- R11: A read with `sel_n` and `rd_n` low drives `rdata_oe` high. With `addr`=1 the read returns the mask. With `addr`=0 it returns the pending register, or the in-service register when the read source bit is set. That bit is loaded by an `addr`=0 write that has bit 4 clear, bit 3 set and is not 0x20, and its data bit 0 (1 = in-service) sets the source. With `sel_n` high, `rdata_oe` stays low.
- R12: A write acts once for each low period of the write strobe, however long the strobe is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sel_n | input | 1 | Active-low select for register reads and writes |
| rd_n | input | 1 | Active-low read strobe |
| wr_n | input | 1 | Active-low write strobe |
| addr | input | 1 | Register address bit |
| wdata | input | 8 | Write data from the CPU |
| rdata | output | 8 | Status byte or vector |
| rdata_oe | output | 1 | High while `rdata` should drive the bus |
| req_in | input | 8 | Asynchronous interrupt request lines |
| ack_n | input | 1 | Active-low interrupt acknowledge pulses |
| irq | output | 1 | Interrupt output to the CPU |

## Verification
The assertions check the following on every cycle:
- `irq` is never high without an unmasked pending bit.
- An edge-mode pending bit is gone one cycle after its synchronized line is low.
- A level-mode line that is high and not being cleared is pending on the next cycle.
- The first acknowledge sets the in-service bit of the winning level, and an end-of-interrupt removes exactly one in-service bit.
- Mask and configuration writes land in the registers.
- The vector phase only follows a first pulse.

Only the bench scenarios can show the rest:
- the exact latency from a request line to `irq`;
- the vector values;
- nested priority, where a lower level is blocked and a higher one preempts;
- the level-7 answer when nothing is pending;
- the single action taken for a long write strobe.

The bench sweeps all single levels and all 256 mask values to cover these.

// File: rtl/irq_hub_pkg.sv
// Package irq_hub_pkg
// Shared types and command encodings for the interrupt controller.
// Assumes an 8-bit CPU data bus.
package irq_hub_pkg;

    typedef enum logic {
        TRIG_EDGE  = 1'b0,
        TRIG_LEVEL = 1'b1
    } trig_mode_e;

    localparam logic [7:0] CMD_EOI      = 8'h20;  // end-of-interrupt code, addr 0
    localparam int         CFG_FLAG_BIT = 4;      // set: configuration word
    localparam int         CFG_TRIG_BIT = 3;      // trigger mode inside config word
    localparam int         SEL_FLAG_BIT = 3;      // set (bit 4 clear): read source word
    localparam int         SEL_SRC_BIT  = 0;      // 1 = in-service, 0 = pending

endpackage

// File: rtl/irq_req_capture.sv
// Module irq_req_capture
// Synchronizes each request line and turns it into a pending bit.
// In edge mode a bit is latched on a rising edge and is dropped when the line
// falls. In level mode the bit follows the line.
// Assumes clr is a one-cycle pulse from the acknowledge logic.
module irq_req_capture #(
    parameter int NREQ        = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NREQ-1:0] req_in,
    input  logic            trig_level,
    input  logic [NREQ-1:0] clr,
    output logic [NREQ-1:0] irr
);

    logic [NREQ-1:0] stage [SYNC_STAGES];
    logic [NREQ-1:0] req_s;
    logic [NREQ-1:0] req_d;
    logic [NREQ-1:0] rise;
    logic [NREQ-1:0] irr_nx;

    // Synchronizer chain and one-cycle delayed copy for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < SYNC_STAGES; k++) stage[k] <= '0;
            req_d <= '0;
        end else begin
            stage[0] <= req_in;
            for (int k = 1; k < SYNC_STAGES; k++) stage[k] <= stage[k-1];
            req_d <= req_s;
        end
    end

    assign req_s = stage[SYNC_STAGES-1];
    assign rise  = req_s & ~req_d;

    // Next pending value for the selected trigger mode.
    always_comb begin
        if (trig_level) irr_nx = req_s & ~clr;
        else            irr_nx = (irr | rise) & req_s & ~clr;
    end

    // Pending register.
    always_ff @(posedge clk) begin
        if (!rst_n) irr <= '0;
        else        irr <= irr_nx;
    end

    for (genvar i = 0; i < NREQ; i++) begin : g_chk
        // R3: edge-mode request is discarded once its line is low
        p_edge_drop_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (!trig_level && !req_s[i]) |=> !irr[i]);
        // R2: level-mode request follows a high line
        p_level_follow_r2: assert property (@(posedge clk) disable iff (!rst_n)
            (trig_level && req_s[i] && !clr[i]) |=> irr[i]);
    end

endmodule

// File: rtl/irq_prio_core.sv
// Module irq_prio_core
// Fixed-priority resolver and in-service register. Index 0 has the highest
// priority. A request may interrupt only if no equal or higher level is in
// service.
// Assumes take, eoi and init are single-cycle pulses.
module irq_prio_core #(
    parameter int LVL_W = 3,
    localparam int NREQ = 1 << LVL_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NREQ-1:0]  irr,
    input  logic [NREQ-1:0]  mask,
    input  logic             take,
    input  logic             eoi,
    input  logic             init,
    output logic [NREQ-1:0]  isr,
    output logic             win_valid,
    output logic [LVL_W-1:0] win_lvl
);

    logic            blocked;
    logic [NREQ-1:0] isr_nx;
    logic            eoi_done;

    // Find the highest-priority request not blocked by an in-service level.
    always_comb begin
        win_valid = 1'b0;
        win_lvl   = '0;
        blocked   = 1'b0;
        for (int i = 0; i < NREQ; i++) begin
            if (!win_valid && !blocked) begin
                if (isr[i]) begin
                    blocked = 1'b1;
                end else if (irr[i] && !mask[i]) begin
                    win_valid = 1'b1;
                    win_lvl   = LVL_W'(i);
                end
            end
        end
    end

    // Next in-service value: EOI clears the lowest bit, take sets the winner.
    always_comb begin
        isr_nx   = isr;
        eoi_done = 1'b0;
        if (eoi) begin
            for (int i = 0; i < NREQ; i++) begin
                if (!eoi_done && isr[i]) begin
                    isr_nx[i] = 1'b0;
                    eoi_done  = 1'b1;
                end
            end
        end
        if (take && win_valid) isr_nx[win_lvl] = 1'b1;
        if (init) isr_nx = '0;
    end

    // In-service register.
    always_ff @(posedge clk) begin
        if (!rst_n) isr <= '0;
        else        isr <= isr_nx;
    end

    // R4: a raised interrupt always has an unmasked pending request behind it
    p_irq_has_source_r4: assert property (@(posedge clk) disable iff (!rst_n)
        win_valid |-> |(irr & ~mask));
    // R6: the first acknowledge marks the winner in service
    p_take_sets_isr_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (take && win_valid && !init) |=> isr[$past(win_lvl)]);
    // R9: end of interrupt removes exactly one in-service bit
    p_eoi_one_bit_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi && !take && !init && (|isr)) |=>
        ($countones(isr) == $countones($past(isr)) - 1));

endmodule

// File: rtl/irq_bus_regs.sv
// Module irq_bus_regs
// CPU register port: decodes writes into mask, vector base, trigger mode,
// read source, end-of-interrupt and configuration pulses.
// Assumes the strobes are synchronous to clk. Each write acts on the first
// cycle of its strobe.
module irq_bus_regs
    import irq_hub_pkg::*;
#(
    parameter int DW    = 8,
    parameter int LVL_W = 3,
    localparam int NREQ = 1 << LVL_W,
    localparam int BASE_W = DW - LVL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_n,
    input  logic              wr_n,
    input  logic              addr,
    input  logic [DW-1:0]     wdata,
    output logic [NREQ-1:0]   mask,
    output logic [BASE_W-1:0] base,
    output trig_mode_e        trig,
    output logic              rd_isr,
    output logic              eoi,
    output logic              init
);

    logic wr_act;
    logic wr_q;
    logic wr_go;
    logic expect_base;

    assign wr_act = !sel_n && !wr_n;
    assign wr_go  = wr_act && !wr_q;
    assign init   = wr_go && !addr && wdata[CFG_FLAG_BIT];
    assign eoi    = wr_go && !addr && (wdata == DW'(CMD_EOI));

    // Remember the strobe so that a long strobe acts once.
    always_ff @(posedge clk) begin
        if (!rst_n) wr_q <= 1'b0;
        else        wr_q <= wr_act;
    end

    // Register loads on the first cycle of a write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask        <= '1;
            base        <= '0;
            trig        <= TRIG_EDGE;
            rd_isr      <= 1'b0;
            expect_base <= 1'b0;
        end else if (wr_go) begin
            if (addr) begin
                if (expect_base) begin
                    base        <= wdata[DW-1:LVL_W];
                    expect_base <= 1'b0;
                end else begin
                    mask <= wdata[NREQ-1:0];
                end
            end else if (wdata[CFG_FLAG_BIT]) begin
                trig        <= trig_mode_e'(wdata[CFG_TRIG_BIT]);
                mask        <= '0;
                expect_base <= 1'b1;
            end else if (wdata[SEL_FLAG_BIT] && wdata != DW'(CMD_EOI)) begin
                rd_isr <= wdata[SEL_SRC_BIT];
            end
        end
    end

    // R5: a mask write lands in the mask register
    p_mask_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_go && addr && !expect_base) |=> (mask == $past(wdata[NREQ-1:0])));
    // R10: a configuration word clears the mask and arms the base load
    p_init_arms_base_r10: assert property (@(posedge clk) disable iff (!rst_n)
        init |=> (mask == '0 && expect_base));

endmodule

// File: rtl/irq_ack_seq.sv
// Module irq_ack_seq
// Two-pulse acknowledge sequencer. The first falling edge of ack_n takes the
// winner, or level 7 when nothing may interrupt. The second falling edge
// drives the vector until ack_n returns high.
// Assumes ack_n is synchronous to clk. Chip select plays no part here.
module irq_ack_seq #(
    parameter int LVL_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ack_n,
    input  logic             win_valid,
    input  logic [LVL_W-1:0] win_lvl,
    output logic             take,
    output logic             vec_drive,
    output logic [LVL_W-1:0] vec_lvl
);

    logic ack_q;
    logic fall;
    logic phase;

    assign fall = !ack_n && ack_q;
    assign take = fall && !phase;

    // Track the pulse count and latch the level chosen on the first pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ack_q     <= 1'b1;
            phase     <= 1'b0;
            vec_drive <= 1'b0;
            vec_lvl   <= '1;
        end else begin
            ack_q <= ack_n;
            if (take) begin
                phase   <= 1'b1;
                vec_lvl <= win_valid ? win_lvl : '1;
            end else if (fall) begin
                phase     <= 1'b0;
                vec_drive <= 1'b1;
            end
            if (ack_n) vec_drive <= 1'b0;
        end
    end

    // R7: the vector phase only follows a first pulse
    p_vec_after_take_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(vec_drive) |-> $past(phase));
    // R8: with nothing to grant, level 7 is latched
    p_spurious_lvl_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !win_valid) |=> (vec_lvl == '1));

endmodule

// File: rtl/irq_hub.sv
// Module irq_hub
// Top of the interrupt controller: request capture, priority core, register
// port and acknowledge sequencer, plus the read/vector output multiplexer.
// Assumes bus strobes and ack_n are synchronous to clk.
module irq_hub
    import irq_hub_pkg::*;
#(
    parameter int LVL_W       = 3,
    parameter int DW          = 8,
    parameter int SYNC_STAGES = 2,
    localparam int NREQ   = 1 << LVL_W,
    localparam int BASE_W = DW - LVL_W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            sel_n,
    input  logic            rd_n,
    input  logic            wr_n,
    input  logic            addr,
    input  logic [DW-1:0]   wdata,
    output logic [DW-1:0]   rdata,
    output logic            rdata_oe,
    input  logic [NREQ-1:0] req_in,
    input  logic            ack_n,
    output logic            irq
);

    logic [NREQ-1:0]   irr;
    logic [NREQ-1:0]   isr;
    logic [NREQ-1:0]   mask;
    logic [NREQ-1:0]   clr;
    logic [BASE_W-1:0] base;
    trig_mode_e        trig;
    logic              rd_isr;
    logic              eoi;
    logic              init;
    logic              take;
    logic              win_valid;
    logic [LVL_W-1:0]  win_lvl;
    logic              vec_drive;
    logic [LVL_W-1:0]  vec_lvl;
    logic              rd_act;

    irq_bus_regs #(.DW(DW), .LVL_W(LVL_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .wr_n(wr_n), .addr(addr),
        .wdata(wdata), .mask(mask), .base(base), .trig(trig),
        .rd_isr(rd_isr), .eoi(eoi), .init(init)
    );

    irq_req_capture #(.NREQ(NREQ), .SYNC_STAGES(SYNC_STAGES)) u_cap (
        .clk(clk), .rst_n(rst_n), .req_in(req_in),
        .trig_level(trig == TRIG_LEVEL), .clr(clr), .irr(irr)
    );

    irq_prio_core #(.LVL_W(LVL_W)) u_core (
        .clk(clk), .rst_n(rst_n), .irr(irr), .mask(mask), .take(take),
        .eoi(eoi), .init(init), .isr(isr), .win_valid(win_valid),
        .win_lvl(win_lvl)
    );

    irq_ack_seq #(.LVL_W(LVL_W)) u_ack (
        .clk(clk), .rst_n(rst_n), .ack_n(ack_n), .win_valid(win_valid),
        .win_lvl(win_lvl), .take(take), .vec_drive(vec_drive),
        .vec_lvl(vec_lvl)
    );

    // Clear the granted pending bit on the first acknowledge pulse.
    always_comb begin
        clr = '0;
        if (take && win_valid) clr[win_lvl] = 1'b1;
    end

    assign irq    = win_valid;
    assign rd_act = !sel_n && !rd_n;

    // Output byte: vector during the second pulse, otherwise selected status.
    always_comb begin
        rdata    = '0;
        rdata_oe = vec_drive || rd_act;
        if (vec_drive)   rdata = {base, vec_lvl};
        else if (addr)   rdata = DW'(mask);
        else if (rd_isr) rdata = DW'(isr);
        else             rdata = DW'(irr);
    end

endmodule

// File: tb/sim_irq_hub.sv
// Bench for irq_hub: reset state, latency, per-level and per-mask sweeps,
// nesting, spurious acknowledge and strobe handling.
module sim_irq_hub;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sel_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1, addr = 1'b0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       rdata_oe;
    logic [7:0] req_in = '0;
    logic       ack_n = 1'b1;
    logic       irq;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    always #10 clk = ~clk;

    irq_hub u0 (
        .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .rd_n(rd_n), .wr_n(wr_n),
        .addr(addr), .wdata(wdata), .rdata(rdata), .rdata_oe(rdata_oe),
        .req_in(req_in), .ack_n(ack_n), .irq(irq)
    );

    task automatic check(input string tag, input logic [7:0] act,
                         input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_write(input logic a, input logic [7:0] d,
                             input int hold = 2, input logic use_sel = 1'b1);
        @(negedge clk);
        sel_n = !use_sel; wr_n = 1'b0; addr = a; wdata = d;
        wait_n(hold);
        sel_n = 1'b1; wr_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic bus_read(input logic a, output logic [7:0] d,
                            output logic oe);
        @(negedge clk);
        sel_n = 1'b0; rd_n = 1'b0; addr = a;
        @(negedge clk);
        d = rdata; oe = rdata_oe;
        sel_n = 1'b1; rd_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic ack_pulse(output logic [7:0] v, output logic oe);
        @(negedge clk);
        ack_n = 1'b0;
        wait_n(2);
        v = rdata; oe = rdata_oe;
        ack_n = 1'b1;
        @(negedge clk);
    endtask

    // Full handshake; returns the vector of the second pulse.
    task automatic ack_pair(output logic [7:0] v, output logic oe1,
                            output logic oe2);
        logic [7:0] d;
        ack_pulse(d, oe1);
        ack_pulse(v, oe2);
    endtask

    function automatic logic [7:0] lowest_zero(input logic [7:0] m);
        for (int i = 0; i < 8; i++) if (!m[i]) return 8'(i);
        return 8'd7;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] d, v;
        logic oe, oe1, oe2;

        wait_n(3);
        rst_n = 1'b1;
        wait_n(1);

        // Reset state
        check("R4 reset irq", {7'd0, irq}, 8'd0);
        check("R11 reset oe", {7'd0, rdata_oe}, 8'd0);
        bus_read(1'b1, d, oe);
        check("R5 reset mask", d, 8'hFF);
        check("R11 read oe", {7'd0, oe}, 8'd1);

        // R11: no output without select
        @(negedge clk); rd_n = 1'b0; addr = 1'b1;
        @(negedge clk); check("R11 no select oe", {7'd0, rdata_oe}, 8'd0);
        rd_n = 1'b1;

        // R10: edge mode, then base 0xA8
        bus_write(1'b0, 8'h10);
        bus_read(1'b1, d, oe);
        check("R10 mask cleared", d, 8'h00);
        bus_write(1'b1, 8'hA8);
        bus_read(1'b1, d, oe);
        check("R10 base write spares mask", d, 8'h00);

        // R5: write without select ignored
        bus_write(1'b1, 8'h55, 2, 1'b0);
        bus_read(1'b1, d, oe);
        check("R5 unselected write", d, 8'h00);

        // R1: latency through synchronizer and capture register
        @(negedge clk); req_in = 8'h08;
        @(negedge clk); @(negedge clk);
        check("R1 not yet after 2 edges", {7'd0, irq}, 8'd0);
        @(negedge clk);
        check("R1 high after 3 edges", {7'd0, irq}, 8'd1);
        req_in = 8'h00;
        wait_n(4);
        check("R3 dropped request", {7'd0, irq}, 8'd0);

        // Single-level sweep in edge mode
        for (int i = 0; i < 8; i++) begin
            bus_write(1'b0, 8'h08);            // read pending register
            @(negedge clk); req_in = 8'(1 << i);
            wait_n(4);
            check("R2 edge request irq", {7'd0, irq}, 8'd1);
            bus_read(1'b0, d, oe);
            check("R11 pending readback", d, 8'(1 << i));
            ack_pair(v, oe1, oe2);
            check("R7 first pulse silent", {7'd0, oe1}, 8'd0);
            check("R7 vector", v, 8'hA8 | 8'(i));
            check("R7 vector oe", {7'd0, oe2}, 8'd1);
            bus_read(1'b0, d, oe);
            check("R6 pending cleared", d, 8'h00);
            bus_write(1'b0, 8'h09);            // read in-service register
            bus_read(1'b0, d, oe);
            check("R6 in service", d, 8'(1 << i));
            bus_write(1'b0, 8'h20);
            bus_read(1'b0, d, oe);
            check("R9 eoi clears", d, 8'h00);
            check("R2 held edge line no rerequest", {7'd0, irq}, 8'd0);
            req_in = 8'h00;
            wait_n(3);
        end

        // R3 then R8: drop before acknowledge, answer is level 7
        @(negedge clk); req_in = 8'h20;
        wait_n(4);
        check("R3 pending before drop", {7'd0, irq}, 8'd1);
        req_in = 8'h00;
        wait_n(4);
        check("R3 discarded", {7'd0, irq}, 8'd0);
        ack_pair(v, oe1, oe2);
        check("R8 spurious vector", v, 8'hAF);
        bus_read(1'b0, d, oe);
        check("R8 no in-service change", d, 8'h00);

        // Nesting: R4 blocking, preemption, R9 lowest bit, R12 long strobe
        @(negedge clk); req_in = 8'h10;
        wait_n(4);
        ack_pair(v, oe1, oe2);
        check("R6 level 4 vector", v, 8'hAC);
        @(negedge clk); req_in = 8'h50;
        wait_n(4);
        check("R4 lower level blocked", {7'd0, irq}, 8'd0);
        @(negedge clk); req_in = 8'h54;
        wait_n(4);
        check("R4 higher level preempts", {7'd0, irq}, 8'd1);
        ack_pair(v, oe1, oe2);
        check("R6 level 2 vector", v, 8'hAA);
        bus_read(1'b0, d, oe);
        check("R6 nested in service", d, 8'h14);
        bus_write(1'b0, 8'h20, 6);
        bus_read(1'b0, d, oe);
        check("R12 long strobe one eoi", d, 8'h10);
        check("R9 level 4 still blocks", {7'd0, irq}, 8'd0);
        bus_write(1'b0, 8'h20);
        check("R4 level 6 now free", {7'd0, irq}, 8'd1);
        ack_pair(v, oe1, oe2);
        check("R6 level 6 vector", v, 8'hAE);
        bus_write(1'b0, 8'h20);
        req_in = 8'h00;
        wait_n(4);

        // Mask sweep in level mode with all lines high
        bus_write(1'b0, 8'h18);
        bus_write(1'b1, 8'h50);
        bus_write(1'b0, 8'h09);
        @(negedge clk); req_in = 8'hFF;
        wait_n(4);
        for (int m = 0; m < 256; m++) begin
            logic [7:0] w;
            bus_write(1'b1, 8'(m));
            check("R4 masked irq", {7'd0, irq}, {7'd0, (m != 255)});
            ack_pair(v, oe1, oe2);
            w = (m != 255) ? lowest_zero(8'(m)) : 8'd7;
            check("R6 priority vector", v, 8'h50 | w);
            bus_read(1'b0, d, oe);
            check("R8 in service by mask", d,
                  (m != 255) ? 8'(1 << w) : 8'h00);
            bus_write(1'b0, 8'h20);
            check("R2 level rerequest", {7'd0, irq}, {7'd0, (m != 255)});
        end
        req_in = 8'h00;
        wait_n(4);
        check("R2 level drop", {7'd0, irq}, 8'd0);

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule